// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches sixteen external interrupt lines and turns events on them into latched pending bits. Each pair of adjacent lines shares one 3-bit detection type: rising edge, falling edge, either edge, low level or high level. Every line first goes through a two-stage synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier. A detected event sets that line's pending bit. A mask register decides which pending bits reach the outputs. The unmasked pending bits are folded into three summary lines for a parent interrupt controller, covering lines 0-3, 4-11 and 12-15.

Software uses a plain single-cycle register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low. No data stream crosses the block boundary, so there is no handshake and no back-pressure.

The register decode uses `bus_addr`:
- 0: the whole configuration word. Field k sits in bits [4k+2:4k] and covers lines 2k and 2k+1.
- 1: pending. A write of 1 to a bit clears that bit.
- 2: mask. A 1 masks the line.
- 3: single-field update. `bus_wdata[7:0]` is the line number and `bus_wdata[18:16]` is the type. This address reads as zero.

Top module: `gxint_ctrl`

## Requirements
- R1: After reset the outputs and registers read as follows.
  - The configuration word reads 0x44444444, so every field holds type 100 (rising edge).
  - Pending reads 0.
  - Mask reads 0xFFFF, so every line is masked.
  - `irq_grp` is 0.
  - Address 3 reads 0.
- R2: A write to address 3 with a line number of 0 to 15 loads `bus_wdata[18:16]` into the field of that line's pair and leaves every other field unchanged. A line number above 15 leaves the whole configuration word unchanged.
- R3: A write to address 0 loads bits [4k+2:4k] into field k for k = 0 to 7. Bits 4k+3 always read back as 0.
- R4: Type encoding, with `x` meaning either value: 000 is low level, 001 is high level, 01x is falling edge, 10x is rising edge and 11x is either edge. An edge type sets the pending bit only on a matching transition of the synchronized input. The bit then stays set after the input settles.
- R5: A level type sets the pending bit on every cycle in which the synchronized input is at the active level. A clear write therefore has no lasting effect while that level holds.
- R6: A write to address 1 clears every pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: If an event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: A write to address 2 loads the mask from `bus_wdata[15:0]`. A masked line still records its events in the pending register.
- R9: `irq_grp[0]` is the OR of pending AND NOT mask over lines 0-3. `irq_grp[1]` covers lines 4-11 and `irq_grp[2]` covers lines 12-15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 16 | External interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_grp | output | 3 | Summary interrupts for line groups 0-3, 4-11 and 12-15 |

## Verification
The faults to look for are:
- a pending bit that fails to latch;
- a clear that touches the wrong bits or beats a simultaneous event;
- a type field written into the wrong pair.

A wrong pending or mask bit shows on the pending or mask readback on the very next cycle. It also raises or drops the matching `irq_grp` line in that same cycle. A misrouted configuration field shows first in the configuration readback. It can also show later as a line that reacts to the wrong transition, about three clocks after the input changes.

// File: rtl/gxint_pkg.sv
package gxint_pkg;
  localparam int LINES   = 16;
  localparam int PAIRS   = LINES / 2;
  localparam int TYPE_W  = 3;
  localparam int FSTRIDE = 4;
  localparam int GROUPS  = 3;
  localparam int DW      = 32;
  localparam int LINE_W  = 8;
  localparam int PAIR_W  = $clog2(PAIRS);
  localparam int TYPE_LSB = 16;

  typedef enum logic [1:0] {
    A_CFG   = 2'd0,
    A_PEND  = 2'd1,
    A_MASK  = 2'd2,
    A_FIELD = 2'd3
  } addr_e;

  typedef logic [TYPE_W-1:0] det_type_t;

  localparam det_type_t RST_TYPE = 3'b100;

  function automatic int grp_lo(int g);
    case (g)
      0:       return 0;
      1:       return 4;
      default: return 12;
    endcase
  endfunction

  function automatic int grp_hi(int g);
    case (g)
      0:       return 3;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic logic line_event(det_type_t t, logic cur, logic prev);
    logic hit;
    casez (t)
      3'b000:  hit = ~cur;
      3'b001:  hit = cur;
      3'b01?:  hit = prev & ~cur;
      3'b10?:  hit = cur & ~prev;
      default: hit = cur ^ prev;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/gxint_sync.sv
module gxint_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign cur = stg[STAGES-1];
endmodule

// File: rtl/gxint_detect.sv
module gxint_detect
  import gxint_pkg::*;
#(
  parameter int N = LINES
) (
  input  det_type_t [N/2-1:0] typ,
  input  logic [N-1:0]        cur,
  input  logic [N-1:0]        prev,
  output logic [N-1:0]        evt
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign evt[i] = line_event(typ[i/2], cur[i], prev[i]);
  end
endmodule

// File: rtl/gxint_regs.sv
module gxint_regs
  import gxint_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic [N-1:0]        evt,
  output det_type_t [N/2-1:0] typ,
  output logic [N-1:0]        pend,
  output logic [N-1:0]        mask,
  output logic [DW-1:0]       bus_rdata
);
  localparam int NP = N / 2;

  logic            wr_en;
  logic [N-1:0]    clr;
  logic            fld_ok;
  logic [LINE_W-1:0] fld_line;
  logic            unused_wbits;

  assign wr_en    = bus_sel & bus_wr;
  assign fld_line = bus_wdata[LINE_W-1:0];
  assign fld_ok   = fld_line < LINE_W'(N);
  assign clr      = (wr_en && bus_addr == A_PEND) ? bus_wdata[N-1:0] : '0;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) typ[k] <= RST_TYPE;
    end else if (wr_en && bus_addr == A_CFG) begin
      for (int k = 0; k < NP; k++) typ[k] <= bus_wdata[FSTRIDE*k +: TYPE_W];
    end else if (wr_en && bus_addr == A_FIELD && fld_ok) begin
      typ[fld_line[PAIR_W:1]] <= bus_wdata[TYPE_LSB +: TYPE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mask <= '1;
    else if (wr_en && bus_addr == A_MASK)  mask <= bus_wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | evt;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CFG:   for (int k = 0; k < NP; k++) bus_rdata[FSTRIDE*k +: TYPE_W] = typ[k];
        A_PEND:  bus_rdata[N-1:0] = pend;
        A_MASK:  bus_rdata[N-1:0] = mask;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gxint_ctrl.sv
module gxint_ctrl
  import gxint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  ext_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [GROUPS-1:0] irq_grp
);
  logic [LINES-1:0]          s_cur;
  logic [LINES-1:0]          s_prev;
  logic [LINES-1:0]          evt;
  det_type_t [PAIRS-1:0]     cfg_typ;
  logic [LINES-1:0]          pend_q;
  logic [LINES-1:0]          mask_q;
  logic [LINES-1:0]          live;
  logic [PAIRS*TYPE_W-1:0]   cfg_flat;

  gxint_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .cur(s_cur), .prev(s_prev)
  );

  gxint_detect #(.N(LINES)) u_det (
    .typ(cfg_typ), .cur(s_cur), .prev(s_prev), .evt(evt)
  );

  gxint_regs #(.N(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt),
    .typ(cfg_typ), .pend(pend_q), .mask(mask_q), .bus_rdata(bus_rdata)
  );

  assign live     = pend_q & ~mask_q;
  assign cfg_flat = cfg_typ;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int HI = grp_hi(g);
    assign irq_grp[g] = |live[HI:LO];
  end
endmodule

// File: rtl/gxint_chk.sv
module gxint_chk #(
  parameter int N  = 16,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  evt,
  input logic [CW-1:0] cfg,
  input logic [2:0]    irq_grp
);
  // R6: cleared bits drop unless an event hit them in the same cycle
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1) |=>
      ((pend & $past(bus_wdata[N-1:0]) & ~$past(evt)) == '0));

  // R7: an event always leaves its bit set
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));

  // R8: mask write loads the mask
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2) |=> (mask == $past(bus_wdata[N-1:0])));

  // R9: no live pending bit means no summary output
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) == '0) |-> (irq_grp == 3'b000));

  // R9: a live pending bit raises some summary output
  a_r9_live: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) != '0) |-> (irq_grp != 3'b000));

  // R2: an out-of-range line number leaves the configuration alone
  a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7:0] > 8'd15) |=> $stable(cfg));
endmodule

bind gxint_ctrl gxint_chk #(.N(16), .CW(24)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend(pend_q), .mask(mask_q),
  .evt(evt), .cfg(cfg_flat), .irq_grp(irq_grp)
);

// File: tb/sim_gxint_ctrl.sv
`timescale 1ns/1ps
module sim_gxint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_grp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gxint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_grp(irq_grp)
  );

  // {line[3:0], type[2:0], v0, v1, expected}
  localparam logic [9:0] VECS [0:10] = '{
    {4'd0,  3'b100, 1'b0, 1'b1, 1'b1},
    {4'd1,  3'b101, 1'b1, 1'b0, 1'b0},
    {4'd2,  3'b010, 1'b1, 1'b0, 1'b1},
    {4'd5,  3'b011, 1'b0, 1'b1, 1'b0},
    {4'd7,  3'b110, 1'b0, 1'b1, 1'b1},
    {4'd8,  3'b111, 1'b1, 1'b0, 1'b1},
    {4'd10, 3'b110, 1'b0, 1'b0, 1'b0},
    {4'd11, 3'b001, 1'b0, 1'b1, 1'b1},
    {4'd12, 3'b001, 1'b0, 1'b0, 1'b0},
    {4'd14, 3'b000, 1'b1, 1'b0, 1'b1},
    {4'd15, 3'b000, 1'b1, 1'b1, 1'b0}
  };

  localparam int GLINES [0:5] = '{0, 3, 4, 11, 12, 15};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bread(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bread(2'd0, rd); chk("R1 cfg", rd, 32'h44444444);
    bread(2'd1, rd); chk("R1 pend", rd, 32'h0);
    bread(2'd2, rd); chk("R1 mask", rd, 32'h0000FFFF);
    bread(2'd3, rd); chk("R1 addr3", rd, 32'h0);
    chk("R1 irq", {29'b0, irq_grp}, 32'h0);

    // R2 field writes
    bwrite(2'd3, {13'b0, 3'b000, 8'd16, 8'd16});
    bread(2'd0, rd); chk("R2 line16 rejected", rd, 32'h44444444);
    bwrite(2'd3, {13'b0, 3'b011, 8'd0, 8'd13});
    bread(2'd0, rd); chk("R2 line13 field", rd, 32'h43444444);
    bwrite(2'd3, {13'b0, 3'b001, 8'd0, 8'hC8});
    bread(2'd0, rd); chk("R2 line200 rejected", rd, 32'h43444444);

    // R3 full word write
    bwrite(2'd0, 32'hFFFFFFFF);
    bread(2'd0, rd); chk("R3 spare bits zero", rd, 32'h77777777);
    bwrite(2'd0, 32'h44444444);
    bread(2'd0, rd); chk("R3 restore", rd, 32'h44444444);

    // R8 mask readback
    bwrite(2'd2, 32'h00001234);
    bread(2'd2, rd); chk("R8 mask load", rd, 32'h00001234);
    bwrite(2'd2, 32'h0000FFFF);

    // R4 / R5 detection vectors
    foreach (VECS[i]) begin
      logic [3:0] ln;
      ln = VECS[i][9:6];
      bwrite(2'd3, {13'b0, VECS[i][5:3], 8'd0, 4'd0, ln});
      ext_in[ln] = VECS[i][2];
      settle();
      bwrite(2'd1, 32'h0000FFFF);
      @(negedge clk);
      ext_in[ln] = VECS[i][1];
      settle();
      bread(2'd1, rd);
      chk((VECS[i][5] | VECS[i][4]) ? "R4 edge vector" : "R5 level vector",
          {31'b0, rd[ln]}, {31'b0, VECS[i][0]});
      bwrite(2'd3, {13'b0, 3'b100, 8'd0, 4'd0, ln});
      ext_in[ln] = 1'b0;
      settle();
    end
    bwrite(2'd1, 32'h0000FFFF);
    bread(2'd1, rd); chk("R6 all cleared", rd, 32'h0);

    // R5 level holds against clear
    bwrite(2'd3, {13'b0, 3'b001, 8'd0, 8'd9});
    ext_in[9] = 1'b1;
    settle();
    bwrite(2'd1, 32'h00000200);
    @(negedge clk);
    bread(2'd1, rd); chk("R5 level survives clear", rd, 32'h00000200);
    ext_in[9] = 1'b0;
    settle();
    bwrite(2'd1, 32'h00000200);
    bread(2'd1, rd); chk("R5 clear after release", rd, 32'h0);
    bwrite(2'd3, {13'b0, 3'b100, 8'd0, 8'd9});

    // R6 zero bits untouched
    ext_in[3] = 1'b1; ext_in[13] = 1'b1;
    settle();
    bwrite(2'd1, 32'h00000008);
    bread(2'd1, rd); chk("R6 selective clear", rd, 32'h00002000);
    bwrite(2'd1, 32'h0000FFFF);
    ext_in = '0;
    settle();

    // R7 event and clear in the same cycle
    @(negedge clk);
    ext_in[6] = 1'b1;
    @(negedge clk);
    bwrite(2'd1, 32'h00000040);
    bread(2'd1, rd); chk("R7 event wins", rd, 32'h00000040);
    bwrite(2'd1, 32'h00000040);
    bread(2'd1, rd); chk("R6 later clear", rd, 32'h0);
    ext_in = '0;
    settle();

    // R8 / R9 masking and grouping
    foreach (GLINES[j]) begin
      int ln;
      logic [2:0] exp_g;
      ln = GLINES[j];
      exp_g = (ln < 4) ? 3'b001 : (ln < 12) ? 3'b010 : 3'b100;
      ext_in[ln] = 1'b1;
      settle();
      bread(2'd1, rd); chk("R8 masked still pending", rd, 32'(1) << ln);
      chk("R9 masked quiet", {29'b0, irq_grp}, 32'h0);
      bwrite(2'd2, ~(32'(1) << ln) & 32'h0000FFFF);
      @(negedge clk);
      chk("R9 group select", {29'b0, irq_grp}, {29'b0, exp_g});
      bwrite(2'd2, 32'h0000FFFF);
      bwrite(2'd1, 32'h0000FFFF);
      ext_in[ln] = 1'b0;
      settle();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule